// File: doc/BRIEF.md
# Pass-through add-on cycle sequencer

This block runs one pass-through transfer between a host-bus target and a device on the add-on side. The host side hands it a request that carries active-low byte enables, a two-bit region number, a direction, a word count, a programmed wait-state count and a transfer address. The sequencer then drives the add-on-side handshake over a shared 32-bit address/data path. It issues an attention indication, an optional address strobe, a data-transfer strobe for each word and a burst flag. It also presents the byte enables, the region and the direction for the whole transfer.

Every cycle is decided from the add-on wait input sampled at the rising edge that starts it. A low sample turns that cycle into a wait state. This holds before the address phase as well as before any data phase. A low sample also stops the programmed wait-state count where it is. The burst flag follows different release rules for reads and for writes, so the add-on can see the end of a burst coming.

Top module: `pt_seq`

## Requirements
- R1: The cycle after a request is accepted is the attention cycle. `attn_n` is low, `be_n` carries the requested active-low enables (bit i low means byte i is used), `region` carries the request region, and `dir` is 1 for a host write and 0 for a host read.
- R2: When `add_wait_n` is sampled low at a rising edge, neither `adr_n` nor `xfer_n` is low in the cycle that follows, and the transfer makes no progress in that cycle.
- R3: With `cfg_addr_en` high at acceptance, the first cycle after the attention cycle whose edge samples wait high is the address phase. In it `adr_n` is low for exactly one cycle, `bus_oe` is 1 and `bus_out` equals the request address. `bus_oe` is 0 in every other cycle.
- R4: With `cfg_addr_en` low at acceptance, `adr_n` stays high for the whole transfer.
- R5: Before each data word, `xfer_n` goes low only after the programmed count of wait-high cycles has passed. The count is reloaded for every word. From the attention cycle through the final transfer cycle, the transfer spans 1 + A + L·(N+1) + W cycles. Here A is 1 if the address phase is enabled, L is the word count, N is the programmed count, and W is the number of wait-low edges sampled during the transfer.
- R6: A wait-low sample holds the programmed wait-state count. Counting resumes from the held value and does not restart.
- R7: In the cycle of the final data transfer, `xfer_n` is low and `attn_n` is high.
- R8: In the cycle after the final data transfer, `be_n` is 4'hF, `busy` is 0 and no strobe is low.
- R9: On a burst read (L > 1, dir 0), `burst_n` is low from the attention cycle until the cycle after the transfer that leaves one word remaining. From then on it stays high.
- R10: On a burst write (L > 1, dir 1), `burst_n` is low from the attention cycle and goes high in the cycle that transfers the second-to-last word. It stays high after that.
- R11: After reset, `busy` is 0, every active-low output is high and `bus_oe` is 0. A request presented while `busy` is 1 is ignored and does not change `region`, `dir` or `be_n`.
- R12: A word count of 0 is treated as a single-word transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request, taken when idle |
| req_be_n | input | 4 | Active-low byte enables of the request |
| req_region | input | 2 | Region number of the request |
| req_write | input | 1 | 1 = host write, 0 = host read |
| req_len | input | 4 | Word count (0 counts as 1) |
| req_ws | input | 4 | Programmed wait states before each word |
| req_addr | input | 32 | Transfer address |
| cfg_addr_en | input | 1 | Enables the address phase |
| add_wait_n | input | 1 | Active-low wait request from the add-on |
| busy | output | 1 | High while a transfer is in progress |
| attn_n | output | 1 | Active-low attention |
| adr_n | output | 1 | Active-low address strobe |
| xfer_n | output | 1 | Active-low data-transfer strobe |
| burst_n | output | 1 | Active-low burst flag |
| be_n | output | 4 | Active-low byte enables to the add-on |
| region | output | 2 | Region number to the add-on |
| dir | output | 1 | Direction to the add-on |
| bus_out | output | 32 | Shared bus value (address during the address phase) |
| bus_oe | output | 1 | Drive enable for the shared bus |

## Verification
Single-word reads with no programmed waits set the shortest path apart from longer ones. A single write with the address phase disabled tells apart configurations that skip that phase and those that keep it. Bursts of two, three and four words in both directions separate the read and write release points of the burst flag. Wait patterns that land before the address phase, between programmed waits and right before a data strobe show whether the programmed count is frozen or restarted. A zero word count and requests held during a busy transfer probe the edge handling of acceptance.

// File: rtl/pt_seq_pkg.sv
package pt_seq_pkg;
    typedef enum logic [1:0] {
        PT_IDLE   = 2'd0,
        PT_ACTIVE = 2'd1,
        PT_DONE   = 2'd2
    } pt_state_e;
endpackage

// File: rtl/pt_ws_timer.sv
module pt_ws_timer #(
    parameter int WS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [WS_W-1:0] load_val,
    input  logic            step,
    output logic            zero
);
    logic [WS_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (step && (cnt_q != '0))
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    AST_WS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/pt_seq.sv
module pt_seq
    import pt_seq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BE_W   = 4,
    parameter int REG_W  = 2,
    parameter int LEN_W  = 4,
    parameter int WS_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BE_W-1:0]   req_be_n,
    input  logic [REG_W-1:0]  req_region,
    input  logic              req_write,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [WS_W-1:0]   req_ws,
    input  logic [DATA_W-1:0] req_addr,
    input  logic              cfg_addr_en,
    input  logic              add_wait_n,
    output logic              busy,
    output logic              attn_n,
    output logic              adr_n,
    output logic              xfer_n,
    output logic              burst_n,
    output logic [BE_W-1:0]   be_n,
    output logic [REG_W-1:0]  region,
    output logic              dir,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe
);
    localparam logic [LEN_W-1:0] ONE_WORD = LEN_W'(1);
    localparam logic [LEN_W-1:0] TWO_WORD = LEN_W'(2);

    typedef struct packed {
        pt_state_e         state;
        logic              attn_n;
        logic              adr_n;
        logic              xfer_n;
        logic              burst_n;
        logic [BE_W-1:0]   be_n;
        logic [REG_W-1:0]  region;
        logic              dir;
        logic [DATA_W-1:0] bus;
        logic              bus_oe;
        logic              addr_pend;
        logic [LEN_W-1:0]  rem;
        logic [WS_W-1:0]   ws_cfg;
        logic [DATA_W-1:0] addr;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        state: PT_IDLE, attn_n: 1'b1, adr_n: 1'b1, xfer_n: 1'b1,
        burst_n: 1'b1, be_n: '1, region: '0, dir: 1'b0, bus: '0,
        bus_oe: 1'b0, addr_pend: 1'b0, rem: '0, ws_cfg: '0, addr: '0};

    seq_t s_d, s_q;
    logic ws_zero, ws_load, ws_step, accept, fire;
    logic [WS_W-1:0] ws_val;
    logic [LEN_W-1:0] len_eff;

    assign len_eff = (req_len == '0) ? ONE_WORD : req_len;
    assign accept  = (s_q.state == PT_IDLE) && req_valid;
    assign fire    = (s_q.state == PT_ACTIVE) && add_wait_n
                     && !s_q.addr_pend && ws_zero;
    assign ws_step = (s_q.state == PT_ACTIVE) && add_wait_n && !s_q.addr_pend;
    assign ws_load = accept || fire;
    assign ws_val  = accept ? req_ws : s_q.ws_cfg;

    pt_ws_timer #(.WS_W(WS_W)) u_ws (
        .clk(clk), .rst_n(rst_n), .load(ws_load), .load_val(ws_val),
        .step(ws_step), .zero(ws_zero)
    );

    always_comb begin
        s_d        = s_q;
        s_d.adr_n  = 1'b1;
        s_d.xfer_n = 1'b1;
        s_d.bus_oe = 1'b0;
        s_d.bus    = '0;
        case (s_q.state)
            PT_IDLE: begin
                if (req_valid) begin
                    s_d.state     = PT_ACTIVE;
                    s_d.attn_n    = 1'b0;
                    s_d.be_n      = req_be_n;
                    s_d.region    = req_region;
                    s_d.dir       = req_write;
                    s_d.rem       = len_eff;
                    s_d.ws_cfg    = req_ws;
                    s_d.addr      = req_addr;
                    s_d.addr_pend = cfg_addr_en;
                    s_d.burst_n   = !(len_eff > ONE_WORD);
                end
            end
            PT_ACTIVE: begin
                if (add_wait_n && s_q.addr_pend) begin
                    s_d.adr_n     = 1'b0;
                    s_d.bus_oe    = 1'b1;
                    s_d.bus       = s_q.addr;
                    s_d.addr_pend = 1'b0;
                end
                if (fire) begin
                    s_d.xfer_n  = 1'b0;
                    s_d.rem     = s_q.rem - 1'b1;
                    s_d.burst_n = s_q.dir ? (s_q.rem <= TWO_WORD)
                                          : (s_q.rem <= ONE_WORD);
                    if (s_q.rem == ONE_WORD) begin
                        s_d.attn_n = 1'b1;
                        s_d.state  = PT_DONE;
                    end
                end else begin
                    s_d.burst_n = s_q.burst_n && (s_q.rem <= ONE_WORD)
                                  ? 1'b1 : (s_q.burst_n || (s_q.rem <= ONE_WORD));
                end
            end
            PT_DONE: begin
                s_d.state   = PT_IDLE;
                s_d.be_n    = '1;
                s_d.burst_n = 1'b1;
            end
            default: s_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SEQ_RST;
        else        s_q <= s_d;
    end

    assign busy    = (s_q.state != PT_IDLE);
    assign attn_n  = s_q.attn_n;
    assign adr_n   = s_q.adr_n;
    assign xfer_n  = s_q.xfer_n;
    assign burst_n = s_q.burst_n;
    assign be_n    = s_q.be_n;
    assign region  = s_q.region;
    assign dir     = s_q.dir;
    assign bus_out = s_q.bus;
    assign bus_oe  = s_q.bus_oe;

    AST_WAIT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        !add_wait_n |=> (adr_n && xfer_n)); // R2
    AST_ADR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !adr_n |=> adr_n); // R3
    AST_NO_ADR_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == PT_ACTIVE && !s_q.addr_pend) |=> adr_n); // R4
    AST_FINAL_ATTN: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_n && s_q.rem == '0) |-> attn_n); // R7
    AST_BE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_n && attn_n) |=> (be_n == '1 && !busy)); // R8
    AST_BURST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (!attn_n && burst_n) |=> burst_n); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (attn_n && adr_n && xfer_n && !bus_oe)); // R11
endmodule

// File: tb/tb_pt_seq.sv
module tb_pt_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_be_n = 4'hF;
    logic [1:0]  req_region = 2'd0;
    logic        req_write = 1'b0;
    logic [3:0]  req_len = 4'd1;
    logic [3:0]  req_ws = 4'd0;
    logic [31:0] req_addr = 32'h0;
    logic        cfg_addr_en = 1'b0;
    logic        add_wait_n = 1'b1;
    logic        busy, attn_n, adr_n, xfer_n, burst_n, dir, bus_oe;
    logic [3:0]  be_n;
    logic [1:0]  region;
    logic [31:0] bus_out;

    pt_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_be_n(req_be_n),
        .req_region(req_region), .req_write(req_write), .req_len(req_len),
        .req_ws(req_ws), .req_addr(req_addr), .cfg_addr_en(cfg_addr_en),
        .add_wait_n(add_wait_n), .busy(busy), .attn_n(attn_n), .adr_n(adr_n),
        .xfer_n(xfer_n), .burst_n(burst_n), .be_n(be_n), .region(region),
        .dir(dir), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    always #2 clk = ~clk;

    integer checks = 0;
    integer errors = 0;
    integer cycles = 0;
    logic [15:0] wpat = 16'hFFFF;
    integer wi = 0;

    // Reference model state, phase 0 idle, 1 running, 2 closing.
    integer m_phase = 0, m_left = 0, m_ws = 0, m_wscfg = 0, m_nwait = 0;
    integer m_base = 0, e_dur = 0, dcount = 0;
    bit     m_addr_due = 0, m_wr = 0;
    logic [31:0] m_addr = 0;
    logic e_attn = 1, e_adr = 1, e_xfer = 1, e_burst = 1, e_busy = 0, e_dir = 0, e_oe = 0;
    logic [3:0]  e_be = 4'hF;
    logic [1:0]  e_reg = 0;
    logic [31:0] e_bus = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        #1;
        add_wait_n <= wpat[wi % 16];
        wi = wi + 1;
    end

    always @(posedge clk) begin
        cycles = cycles + 1;
        if (!rst_n) begin
            m_phase = 0;
        end else begin
            e_adr = 1; e_xfer = 1; e_oe = 0; e_bus = 0;
            if (m_phase == 0) begin
                if (req_valid) begin
                    m_phase = 1;
                    m_left = (req_len == 0) ? 1 : int'(req_len);
                    m_wscfg = int'(req_ws); m_ws = m_wscfg;
                    m_addr_due = cfg_addr_en; m_addr = req_addr; m_wr = req_write;
                    m_nwait = 0;
                    m_base = 1 + (cfg_addr_en ? 1 : 0) + m_left * (m_wscfg + 1);
                    e_attn = 0; e_be = req_be_n; e_reg = req_region; e_dir = req_write;
                    e_burst = (m_left > 1) ? 1'b0 : 1'b1;
                end
            end else if (m_phase == 1) begin
                if (!add_wait_n) begin
                    m_nwait = m_nwait + 1;
                end else if (m_addr_due) begin
                    m_addr_due = 0; e_adr = 0; e_oe = 1; e_bus = m_addr;
                end else if (m_ws > 0) begin
                    m_ws = m_ws - 1;
                end else begin
                    e_xfer = 0;
                    if (m_wr && m_left == 2) e_burst = 1;
                    m_left = m_left - 1;
                    m_ws = m_wscfg;
                    if (m_left == 0) begin
                        e_attn = 1; m_phase = 2; e_dur = m_base + m_nwait;
                    end
                end
                if (e_xfer && m_left <= 1) e_burst = 1;
            end else begin
                m_phase = 0; e_be = 4'hF; e_burst = 1;
            end
            e_busy = (m_phase != 0);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1 attn_n", attn_n, e_attn);
            chk("R3/R4 adr_n", adr_n, e_adr);
            chk("R5 xfer_n", xfer_n, e_xfer);
            chk(e_dir ? "R10 burst_n" : "R9 burst_n", burst_n, e_burst);
            chk("R8 be_n", be_n, e_be);
            chk("R1/R11 region", region, e_reg);
            chk("R1 dir", dir, e_dir);
            chk("R3 bus_oe", bus_oe, e_oe);
            chk("R3 bus_out", bus_out, e_bus);
            chk("R11 busy", busy, e_busy);
            if (!attn_n) dcount = dcount + 1;
            if (!xfer_n && attn_n) begin
                chk("R5/R6 duration", dcount + 1, e_dur);
                dcount = 0;
            end
        end
    end

    task automatic run(input logic wr, input logic [3:0] len, input logic [3:0] ws,
                       input logic aen, input logic [15:0] pat, input logic [1:0] rg);
        @(posedge clk); #1;
        wpat = pat;
        req_valid = 1; req_write = wr; req_len = len; req_ws = ws;
        cfg_addr_en = aen; req_region = rg; req_be_n = {rg, ~rg};
        req_addr = {8'hA5, 4'h0, len, 4'h0, ws, 6'h0, rg, 3'h0, wr};
        @(posedge clk); #1;
        req_valid = 0;
        while (m_phase != 0) begin @(posedge clk); #1; end
        wpat = 16'hFFFF;
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state at the ports
        chk("R11 reset busy", busy, 0);
        chk("R11 reset strobes", {attn_n, adr_n, xfer_n, burst_n}, 4'hF);
        chk("R11 reset be_n", be_n, 4'hF);
        chk("R11 reset bus_oe", bus_oe, 0);
        rst_n = 1;
        run(0, 4'd1, 4'd0, 1, 16'hFFFF, 2'd1);   // R1 R3 R7 R8 single read
        run(1, 4'd1, 4'd2, 0, 16'hFFFF, 2'd2);   // R4 R5 single write
        run(0, 4'd4, 4'd1, 1, 16'hF3D9, 2'd3);   // R2 R9 burst read with waits
        run(1, 4'd3, 4'd3, 1, 16'hB6DB, 2'd0);   // R6 R10 burst write, waits mid count
        run(1, 4'd2, 4'd0, 0, 16'hFFFF, 2'd1);   // R10 two-word write
        run(0, 4'd2, 4'd2, 0, 16'hEEEE, 2'd2);   // R9 two-word read
        run(0, 4'd0, 4'd1, 1, 16'hFFFF, 2'd3);   // R12 zero length
        // R11 requests while busy are ignored
        @(posedge clk); #1;
        req_valid = 1; req_write = 1; req_len = 4'd3; req_ws = 4'd2;
        cfg_addr_en = 1; req_region = 2'd1; req_be_n = 4'h3; req_addr = 32'h1234_5678;
        @(posedge clk); #1;
        req_region = 2'd2; req_write = 0; req_be_n = 4'h5;
        repeat (3) @(posedge clk);
        #1;
        chk("R11 region held while busy", region, 2'd1);
        chk("R11 be_n held while busy", be_n, 4'h3);
        req_valid = 0;
        while (m_phase != 0) begin @(posedge clk); #1; end
        repeat (3) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog R11 actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule